// File: doc/BRIEF.md
# Column Token-Seek Hit Readout

This block reads out one column of hit pixels. A token walks the column's hit flags from row 0 upward. It passes over empty rows in one cycle each and stops at every row whose flag is set. Each stop goes to one of four read channels, taken in rotation. That channel asks an external ramp converter for a 5-bit amplitude code. It then stores the row number and the code together in its own four-entry queue, and sends a one-cycle reset back to the served pixel so that the pixel drops its flag.

A single downstream port drains the four queues with a valid/ready handshake. It always offers the lowest-numbered channel that holds data. An external veto input throws away everything queued at once. Any conversion that overlaps a veto cycle is discarded when it completes, but its pixel is still reset. A start pulse begins a scan. A done flag reports that the token has passed the last row and that every channel has gone quiet.

Top module: `colTokenReadout`

## Requirements
- R1: While reset is held, and in the first cycle after it, `outValid`, `adcStart`, `pixReset` and `scanDone` are all zero.
- R2: During a scan the token stops only at rows whose hit flag is set. Those rows are dispatched in ascending order, and `adcRow` of the started channel carries the dispatched row.
- R3: The k-th hit of a scan (k counted from 0) goes to channel k mod 4. Every scan begins at channel 0.
- R4: `adcStart[c]` is a one-cycle pulse, raised in the cycle after a dispatch. Channel c starts no new conversion until its previous one has ended with `adcDone[c]`.
- R5: At the edge where `adcDone[c]` is seen, the pair (row, code) is written into channel c's queue. The code is taken from `adcCode[5c+4:5c]` and the row fills the upper bits of the stored word. `pixReset` of that row is high for exactly the following cycle, and only rows that were dispatched are ever reset.
- R6: Each channel queue holds 4 entries and never overflows. The token stalls on a hit row while the target channel is converting or its queue is full, and moves on once space frees.
- R7: `outValid` is high when any queue holds data and `veto` is low. The port presents the lowest-numbered non-empty channel on `outChan`, `outRow` and `outCode`. A word leaves at an edge with `outValid` and `outReady` high, and each channel's words leave in the order they were written.
- R8: At an edge with `veto` high, all queues are emptied and no word is written or taken. A conversion whose window, from its `adcStart` cycle through its `adcDone` cycle, includes a veto cycle is not written, but its pixel is still reset.
- R9: `scanDone` rises once the token is past the last row and all channels are idle. A `scanStart` pulse clears it and starts a scan from row 0. A `scanStart` that arrives while a scan is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanStart | input | 1 | Pulse that begins a scan |
| hitFlags | input | ROWS | Per-row hit flags of the column |
| pixReset | output | ROWS | One-cycle reset to a served pixel |
| adcStart | output | 4 | Per-channel conversion start pulse |
| adcRow | output | 4*RW | Per-channel row being converted |
| adcDone | input | 4 | Per-channel conversion finished |
| adcCode | input | 4*5 | Per-channel 5-bit amplitude code |
| veto | input | 1 | Discard all queued and in-flight hits |
| outValid | output | 1 | Output word available |
| outReady | input | 1 | Downstream accepts the word |
| outChan | output | 2 | Channel the word comes from |
| outRow | output | RW | Row address of the word |
| outCode | output | 5 | Amplitude code of the word |
| scanDone | output | 1 | Scan finished, all channels idle |

## Verification
A veto can arrive at the same edge as a conversion finishing, or as a word leaving on the output port. In either case the flush must win: the finished hit is dropped, and the word offered in that cycle does not count as delivered. The bench provokes these collisions with veto pulses placed while channels are converting and the output is draining under a toggling ready pattern. A behavioural queue model, updated with the same edge rules, judges every cycle's `outValid`, `outChan`, `outRow` and `outCode`.

// File: rtl/colro_pkg.sv
package colro_pkg;
  localparam int CH_COUNT = 4;
  localparam int CH_W = $clog2(CH_COUNT);
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {CH_IDLE, CH_CONV, CH_RST} chState_e;

  typedef struct packed {
    logic [CH_COUNT-1:0] push;
    logic [CH_COUNT-1:0] pop;
    logic                flush;
  } dpStrobe_t;
endpackage

// File: rtl/colFifo.sv
module colFifo #(
  parameter int DEPTH = 4,
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(push && full && !flush));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(pop && empty));
endmodule

// File: rtl/colDatapath.sv
module colDatapath
  import colro_pkg::*;
#(
  parameter int ROWS = 32,
  parameter int DEPTH = 4,
  localparam int RW = $clog2(ROWS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strb,
  input  logic [CH_COUNT*RW-1:0]     chRowBus,
  input  logic [CH_COUNT*CODE_W-1:0] adcCode,
  input  logic [CH_W-1:0]            outSel,
  output logic [CH_COUNT-1:0]        fifoFull,
  output logic [CH_COUNT-1:0]        fifoEmpty,
  output logic [RW-1:0]              outRow,
  output logic [CODE_W-1:0]          outCode
);
  localparam int EW = RW + CODE_W;

  logic [EW-1:0] headWord [CH_COUNT];

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_chan
    colFifo #(.DEPTH(DEPTH), .W(EW)) fifo_i (
      .clk    (clk),
      .rstN   (rstN),
      .push   (strb.push[c]),
      .pop    (strb.pop[c]),
      .flush  (strb.flush),
      .wrData ({chRowBus[c*RW +: RW], adcCode[c*CODE_W +: CODE_W]}),
      .rdData (headWord[c]),
      .full   (fifoFull[c]),
      .empty  (fifoEmpty[c])
    );
  end

  assign {outRow, outCode} = headWord[outSel];
endmodule

// File: rtl/colCtrl.sv
module colCtrl
  import colro_pkg::*;
#(
  parameter int ROWS = 32,
  localparam int RW = $clog2(ROWS),
  localparam int TW = $clog2(ROWS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   scanStart,
  input  logic [ROWS-1:0]        hitFlags,
  input  logic [CH_COUNT-1:0]    adcDone,
  input  logic                   veto,
  input  logic                   outReady,
  input  logic [CH_COUNT-1:0]    fifoFull,
  input  logic [CH_COUNT-1:0]    fifoEmpty,
  output dpStrobe_t              strb,
  output logic [ROWS-1:0]        pixReset,
  output logic [CH_COUNT-1:0]    adcStart,
  output logic [CH_COUNT*RW-1:0] chRowBus,
  output logic                   scanDone,
  output logic                   outValid,
  output logic [CH_W-1:0]        outSel
);
  chState_e        chState [CH_COUNT];
  logic [RW-1:0]   chRow   [CH_COUNT];
  logic [CH_COUNT-1:0] chDrop;
  logic [CH_COUNT-1:0] startR;
  logic [TW-1:0]   tokRow;
  logic [CH_W-1:0] nextCh;
  logic            scanning;

  logic atEnd, curHit, tgtFree, takeHit, stepTok, allIdle;

  always_comb begin
    atEnd   = (tokRow == TW'(ROWS));
    curHit  = !atEnd && hitFlags[tokRow[RW-1:0]];
    tgtFree = (chState[nextCh] == CH_IDLE) && !fifoFull[nextCh];
    takeHit = scanning && curHit && tgtFree;
    stepTok = scanning && !atEnd && (!curHit || tgtFree);
    allIdle = 1'b1;
    for (int c = 0; c < CH_COUNT; c++)
      if (chState[c] != CH_IDLE) allIdle = 1'b0;
  end

  // Output merge: lowest-numbered non-empty channel first
  always_comb begin
    outSel = '0;
    for (int c = CH_COUNT - 1; c >= 0; c--)
      if (!fifoEmpty[c]) outSel = CH_W'(c);
    outValid = !(&fifoEmpty) && !veto;
  end

  always_comb begin
    strb.flush = veto;
    pixReset   = '0;
    for (int c = 0; c < CH_COUNT; c++) begin
      strb.push[c] = (chState[c] == CH_CONV) && adcDone[c] && !chDrop[c] && !veto;
      strb.pop[c]  = outValid && outReady && (outSel == CH_W'(c));
      if (chState[c] == CH_RST) pixReset[chRow[c]] = 1'b1;
      chRowBus[c*RW +: RW] = chRow[c];
    end
  end

  assign adcStart = startR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanning <= 1'b0;
      scanDone <= 1'b0;
      tokRow   <= '0;
      nextCh   <= '0;
    end else if (scanStart && !scanning) begin
      scanning <= 1'b1;
      scanDone <= 1'b0;
      tokRow   <= '0;
      nextCh   <= '0;
    end else if (scanning) begin
      if (stepTok) tokRow <= tokRow + 1'b1;
      if (takeHit) nextCh <= (nextCh == CH_W'(CH_COUNT - 1)) ? '0 : nextCh + 1'b1;
      if (atEnd && allIdle) begin
        scanning <= 1'b0;
        scanDone <= 1'b1;
      end
    end
  end

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_chFsm
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chState[c] <= CH_IDLE;
        chRow[c]   <= '0;
        chDrop[c]  <= 1'b0;
        startR[c]  <= 1'b0;
      end else begin
        startR[c] <= 1'b0;
        case (chState[c])
          CH_IDLE: if (takeHit && nextCh == CH_W'(c)) begin
            chState[c] <= CH_CONV;
            chRow[c]   <= tokRow[RW-1:0];
            chDrop[c]  <= 1'b0;
            startR[c]  <= 1'b1;
          end
          CH_CONV: begin
            if (adcDone[c]) chState[c] <= CH_RST;
            else            chDrop[c]  <= chDrop[c] | veto;
          end
          default: chState[c] <= CH_IDLE;
        endcase
      end
    end

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
      adcStart[c] |=> !adcStart[c]);
  end

  assert_token_forward_R2: assert property (@(posedge clk) disable iff (!rstN)
    (scanning && $past(scanning)) |-> (tokRow >= $past(tokRow)));
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> (adcStart == '0 && pixReset == '0));
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    veto |=> !outValid);
endmodule

// File: rtl/colTokenReadout.sv
module colTokenReadout
  import colro_pkg::*;
#(
  parameter int ROWS = 32,
  parameter int DEPTH = 4,
  localparam int RW = $clog2(ROWS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       scanStart,
  input  logic [ROWS-1:0]            hitFlags,
  output logic [ROWS-1:0]            pixReset,
  output logic [CH_COUNT-1:0]        adcStart,
  output logic [CH_COUNT*RW-1:0]     adcRow,
  input  logic [CH_COUNT-1:0]        adcDone,
  input  logic [CH_COUNT*CODE_W-1:0] adcCode,
  input  logic                       veto,
  output logic                       outValid,
  input  logic                       outReady,
  output logic [CH_W-1:0]            outChan,
  output logic [RW-1:0]              outRow,
  output logic [CODE_W-1:0]          outCode,
  output logic                       scanDone
);
  dpStrobe_t           strb;
  logic [CH_COUNT-1:0] fifoFull, fifoEmpty;

  colCtrl #(.ROWS(ROWS)) ctrl_i (
    .clk(clk), .rstN(rstN), .scanStart(scanStart), .hitFlags(hitFlags),
    .adcDone(adcDone), .veto(veto), .outReady(outReady),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .strb(strb),
    .pixReset(pixReset), .adcStart(adcStart), .chRowBus(adcRow),
    .scanDone(scanDone), .outValid(outValid), .outSel(outChan)
  );

  colDatapath #(.ROWS(ROWS), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .chRowBus(adcRow),
    .adcCode(adcCode), .outSel(outChan), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .outRow(outRow), .outCode(outCode)
  );
endmodule

// File: tb/colTokenReadout_tb_top.sv
module colTokenReadout_tb_top;
  import colro_pkg::*;
  localparam int ROWS = 32;
  localparam int RW = 5;
  localparam int CH = CH_COUNT;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, scanStart, veto, outReady, outValid, scanDone;
  logic [ROWS-1:0] hitFlags, pixReset;
  logic [CH-1:0] adcStart, adcDone;
  logic [CH*RW-1:0] adcRow;
  logic [CH*CODE_W-1:0] adcCode;
  logic [CH_W-1:0] outChan;
  logic [RW-1:0] outRow;
  logic [CODE_W-1:0] outCode;

  colTokenReadout #(.ROWS(ROWS), .DEPTH(4)) dut_i (.*);

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int codeOf(input int row);
    return (row * 11 + 5) % 32;
  endfunction

  // behavioural model state
  logic [ROWS-1:0] hitModel = '0;
  int  dispList[$];
  int  dispIdx = 0;
  bit  scanningM = 0, rstDone = 0, expectDoneLow = 0;
  int  scanDoneCnt = 0, resetCount = 0, readyMode = 1;
  bit  readyReq, vetoReq = 0, startReq = 0;
  bit  pend[ROWS];
  bit  convAct[CH], convDrop[CH];
  int  convRow[CH], convCnt[CH];
  int  q[CH][$];
  int  cyc = 0;

  always @(negedge clk) begin : monitor
    bit any, rNew, vNew, sNew;
    int lo, r;
    logic [CH-1:0] doneV;
    if (rstDone) begin
      cyc++;
      any = 0; lo = 0;
      for (int c = CH - 1; c >= 0; c--) if (q[c].size() > 0) begin any = 1; lo = c; end
      check(outValid == (any && !veto), "R7", "outValid", outValid, any && !veto);
      if (outValid && any) begin
        check(outChan == lo, "R7", "outChan", outChan, lo);
        check(int'({outRow, outCode}) == q[lo][0], "R5", "stored row/code",
              int'({outRow, outCode}), q[lo][0]);
      end
      if (expectDoneLow) begin
        check(scanDone == 1'b0, "R9", "scanDone cleared by start", scanDone, 0);
        expectDoneLow = 0;
      end
      for (int c = 0; c < CH; c++) if (adcStart[c]) begin
        r = int'(adcRow[c*RW +: RW]);
        check(!convAct[c], "R4", "start while converting", c, -1);
        check(dispIdx < dispList.size(), "R2", "dispatch count", dispIdx + 1, dispList.size());
        if (dispIdx < dispList.size())
          check(r == dispList[dispIdx], "R2", "dispatched row", r, dispList[dispIdx]);
        check(c == dispIdx % CH, "R3", "dispatch channel", c, dispIdx % CH);
        dispIdx++;
        convAct[c] = 1; convRow[c] = r; convCnt[c] = LAT; convDrop[c] = 0; pend[r] = 1;
      end
      for (int rr = 0; rr < ROWS; rr++) if (pixReset[rr]) begin
        check(pend[rr], "R5", "reset of undispatched row", rr, -1);
        pend[rr] = 0; hitModel[rr] = 1'b0; resetCount++;
      end
      if (scanDone && scanningM) begin
        check(hitModel == '0, "R9", "hits left at scanDone", int'(hitModel), 0);
        scanningM = 0; scanDoneCnt++;
      end
      // next inputs
      rNew = (readyMode == 1) || (readyMode == 2 && (cyc % 3 != 0));
      vNew = vetoReq; vetoReq = 0;
      sNew = startReq; startReq = 0;
      if (sNew && !scanningM) begin
        dispList.delete(); dispIdx = 0; scanningM = 1; expectDoneLow = 1;
        for (int rr = 0; rr < ROWS; rr++) if (hitModel[rr]) dispList.push_back(rr);
      end
      doneV = '0;
      for (int c = 0; c < CH; c++) if (convAct[c]) begin
        if (convCnt[c] == 0) begin
          doneV[c] = 1'b1;
          adcCode[c*CODE_W +: CODE_W] = CODE_W'(codeOf(convRow[c]));
        end else convCnt[c]--;
      end
      // edge effects on the model
      if (any && rNew && !vNew) void'(q[lo].pop_front());
      for (int c = 0; c < CH; c++) if (doneV[c]) begin
        if (!convDrop[c] && !vNew) q[c].push_back(convRow[c] * 32 + codeOf(convRow[c]));
        convAct[c] = 0;
      end
      if (vNew) for (int c = 0; c < CH; c++) begin
        q[c].delete();
        if (convAct[c]) convDrop[c] = 1;
      end
      hitFlags = hitModel; outReady = rNew; veto = vNew; scanStart = sNew; adcDone = doneV;
    end
  end

  task automatic waitDone();
    int target;
    target = scanDoneCnt + 1;
    while (scanDoneCnt < target) @(posedge clk);
  endtask

  task automatic runScan(input logic [ROWS-1:0] hits, input int mode);
    @(posedge clk);
    hitModel = hits; readyMode = mode; startReq = 1;
    waitDone();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int base;
    rstN = 0; scanStart = 0; veto = 0; outReady = 0; hitFlags = '0;
    adcDone = '0; adcCode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 0 && scanDone == 0, "R1", "valid/done in reset", outValid, 0);
    check(adcStart == '0 && pixReset == '0, "R1", "start/reset in reset", int'(adcStart), 0);
    rstN = 1;
    @(negedge clk);
    check(outValid == 0 && scanDone == 0 && adcStart == '0 && pixReset == '0,
          "R1", "outputs after reset", int'(pixReset), 0);
    rstDone = 1;

    // sparse hits, ready always high (R2, R3, R5, R7)
    runScan(32'h8000_0239, 1);

    // stall: 24 hits with no draining fill all queues (R6)
    @(posedge clk);
    base = resetCount;
    hitModel = 32'h00FF_FFFF; readyMode = 0; startReq = 1;
    repeat (300) @(posedge clk);
    check(resetCount - base == 16, "R6", "served before stall", resetCount - base, 16);
    check(dispIdx == 16, "R6", "dispatches before stall", dispIdx, 16);
    check(scanDone == 0, "R6", "scanDone while stalled", scanDone, 0);
    readyMode = 1;
    waitDone();
    check(resetCount - base == 24, "R6", "all served after drain", resetCount - base, 24);

    // veto during queued and in-flight data, ignored restart (R8, R9)
    @(posedge clk);
    base = resetCount;
    hitModel = 32'h5555_5555; readyMode = 0; startReq = 1;
    repeat (20) @(posedge clk);
    vetoReq = 1;
    repeat (3) @(posedge clk);
    startReq = 1;
    repeat (9) @(posedge clk);
    readyMode = 2;
    repeat (5) @(posedge clk);
    vetoReq = 1;
    waitDone();
    check(resetCount - base == 16, "R8", "vetoed pixels still reset", resetCount - base, 16);

    // empty column (R2, R9)
    runScan('0, 1);
    check(dispIdx == 0, "R2", "dispatches on empty column", dispIdx, 0);

    // dense ends with throttled output (R3, R7)
    runScan(32'hF000_000F | 32'h0001_8000, 2);

    readyMode = 1;
    repeat (40) @(posedge clk);
    for (int c = 0; c < CH; c++)
      check(q[c].size() == 0, "R7", "undelivered words", q[c].size(), 0);
    check(outValid == 0, "R7", "outValid at idle", outValid, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule